// File: doc/BRIEF.md
# Per-CPU Interrupt Presentation Unit

This block sits next to one processor and keeps a single slot for the interrupt that processor should take next. Source controllers offer it deliveries (a source number, a priority and an identifier for the offering controller). The unit takes an offer only when it beats both the processor's current priority and whatever already sits in the slot. An offer it refuses is bounced back with a reject pulse. An offer it takes pushes out a weaker pending entry, and that entry's owner is told through a displacement reject.

The processor drives the unit with one-cycle commands. It can change its current priority, program a software inter-processor interrupt (IPI) request priority, accept the pending interrupt, poll the state, and signal end of interrupt. The unit drives a level interrupt line to the processor. Toward the source layer it emits end-of-interrupt and resend-request pulses. A lower number always means a more favoured priority, and 0xFF means least favoured or none.

Top module: `irq_presenter`

## Requirements
- R1: After reset the 32-bit interrupt word (current priority in bits 31:24, pending source in bits 23:0) reads 0, the IPI request priority reads 0xFF and the interrupt line is low.
- R2: A delivery is refused, with `dlv_rej_o` high one cycle later, when its priority is numerically at least the current priority, or when a source is pending whose priority is numerically at most the offered one.
- R3: A taken delivery replaces the pending entry. If that entry came from a source controller, a displacement pulse one cycle later carries its source number and owner. An IPI entry (source number 2) is replaced with no displacement pulse.
- R4: Accept (op 3) returns the pre-command interrupt word on `rd_word_o` with `rd_valid_o`, loads the current priority from the pending priority, clears the pending source and drops the interrupt line.
- R5: Set-current-priority (op 1, value in data bits 7:0) with a more favoured value empties a pending slot whose priority is numerically at least the new value, drops the line and sends a displacement pulse to its owner.
- R6: Set-current-priority with an equal or less favoured value on an empty slot pulses `resend_o`. If the IPI priority is then more favoured than the current one, an IPI is made pending.
- R7: Set-IPI-priority (op 2, value in data bits 7:0) more favoured than the current priority makes source 2 pending at that priority, displacing an owned entry. It does nothing when the pending entry is at least as favoured.
- R8: End of interrupt (op 5) loads the current priority from data bits 31:24 and pulses `eoi_o` with the source in bits 23:0. It also performs the R6 resend only when the slot is empty.
- R9: Poll (op 4) returns the interrupt word and the IPI priority and changes no state.
- R10: When a command and a delivery arrive in the same cycle, the command is applied first and the delivery is judged against the result.
- R11: The interrupt line is high exactly when the pending source field is non-zero. All result pulses appear one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dlv_valid_i | input | 1 | Delivery strobe from a source controller |
| dlv_src_i | input | 24 | Offered source number |
| dlv_prio_i | input | 8 | Offered priority |
| dlv_own_i | input | 4 | Identifier of the offering controller |
| cmd_valid_i | input | 1 | Processor command strobe |
| cmd_op_i | input | 3 | Command code (1 set priority, 2 set IPI, 3 accept, 4 poll, 5 end of interrupt) |
| cmd_data_i | input | 32 | Command operand |
| cpu_irq_o | output | 1 | Level interrupt to the processor |
| rd_valid_o | output | 1 | Read result valid (accept or poll) |
| rd_word_o | output | 32 | Interrupt word read |
| rd_ipi_o | output | 8 | IPI request priority read |
| dlv_rej_o | output | 1 | Offer refused |
| disp_o | output | 1 | Pending entry displaced back to its owner |
| disp_src_o | output | 24 | Source number of displaced entry |
| disp_own_o | output | 4 | Owner of displaced entry |
| eoi_o | output | 1 | End-of-interrupt pulse toward sources |
| eoi_src_o | output | 24 | Source number being ended |
| resend_o | output | 1 | Request that sources re-offer refused interrupts |

## Verification
A corrupted pending priority shows up on the next delivery. The accept or refuse decision flips, and that is seen on `dlv_rej_o` or on the displacement pulse one cycle later. A wrong current priority is read back by the next poll and changes the next IPI check. A lost owner flag shows as a missing or extra displacement pulse, so any slot error reaches a port within one or two strobes after it arises.

// File: rtl/irqp_pkg.sv
// Shared widths, command codes and slot record for the presentation unit.
// Assumes one presenter per processor; widths are fixed for the whole chip.
package irqp_pkg;
    localparam int SRC_W  = 24;
    localparam int PRIO_W = 8;
    localparam int OWN_W  = 4;
    localparam int WORD_W = SRC_W + PRIO_W;
    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_SET_CUR = 3'd1,
        OP_SET_IPI = 3'd2,
        OP_ACCEPT  = 3'd3,
        OP_POLL    = 3'd4,
        OP_EOI     = 3'd5
    } op_e;

    typedef struct packed {
        logic [PRIO_W-1:0] cur;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] pend;
        logic [OWN_W-1:0]  own;
        logic              own_v;
        logic [PRIO_W-1:0] ipi;
    } slot_t;

    typedef struct packed {
        logic             v;
        logic [SRC_W-1:0] src;
        logic [OWN_W-1:0] own;
    } disp_t;
endpackage

// File: rtl/irqp_cmd_stage.sv
// Applies one processor command to the slot state (combinational).
// Assumes at most one command per cycle; emits at most one displacement.
module irqp_cmd_stage
    import irqp_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  slot_t             st_i,
    output slot_t             st_o,
    output disp_t             disp_o,
    output logic              eoi_o,
    output logic [SRC_W-1:0]  eoi_src_o,
    output logic              resend_o,
    output logic              rd_o
);
    logic [PRIO_W-1:0] val;
    logic              do_resend;
    logic              do_check;

    assign val = cmd_data[PRIO_W-1:0];

    // Next state from the command, then the resend and IPI check it triggers.
    always_comb begin
        st_o      = st_i;
        disp_o    = '0;
        eoi_o     = 1'b0;
        eoi_src_o = '0;
        resend_o  = 1'b0;
        rd_o      = 1'b0;
        do_resend = 1'b0;
        do_check  = 1'b0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_SET_CUR: begin
                    st_o.cur = val;
                    if (val < st_i.cur) begin
                        if (st_i.src != '0 && val <= st_i.pend) begin
                            st_o.src   = '0;
                            st_o.pend  = PRIO_NONE;
                            st_o.own_v = 1'b0;
                            st_o.own   = '0;
                            if (st_i.own_v) disp_o = '{1'b1, st_i.src, st_i.own};
                        end
                    end else if (st_i.src == '0) begin
                        do_resend = 1'b1;
                    end
                end
                OP_SET_IPI: begin
                    st_o.ipi = val;
                    if (val < st_i.cur) do_check = 1'b1;
                end
                OP_ACCEPT: begin
                    rd_o       = 1'b1;
                    st_o.cur   = st_i.pend;
                    st_o.src   = '0;
                    st_o.pend  = PRIO_NONE;
                    st_o.own_v = 1'b0;
                    st_o.own   = '0;
                end
                OP_POLL: rd_o = 1'b1;
                OP_EOI: begin
                    st_o.cur  = cmd_data[WORD_W-1:SRC_W];
                    eoi_o     = 1'b1;
                    eoi_src_o = cmd_data[SRC_W-1:0];
                    if (st_i.src == '0) do_resend = 1'b1;
                end
                default: ;
            endcase
        end
        if (do_resend) begin
            resend_o = 1'b1;
            if (st_o.ipi < st_o.cur) do_check = 1'b1;
        end
        if (do_check && !(st_o.src != '0 && st_o.pend <= st_o.ipi)) begin
            if (st_o.src != '0 && st_o.own_v) disp_o = '{1'b1, st_o.src, st_o.own};
            st_o.src   = IPI_SRC;
            st_o.pend  = st_o.ipi;
            st_o.own_v = 1'b0;
            st_o.own   = '0;
        end
    end
endmodule

// File: rtl/irqp_dlv_stage.sv
// Judges one delivery against the post-command slot state (combinational).
// Assumes the offered source number is non-zero.
module irqp_dlv_stage
    import irqp_pkg::*;
(
    input  logic              dlv_valid,
    input  logic [SRC_W-1:0]  dlv_src,
    input  logic [PRIO_W-1:0] dlv_prio,
    input  logic [OWN_W-1:0]  dlv_own,
    input  slot_t             st_i,
    output slot_t             st_o,
    output logic              rej_o,
    output disp_t             disp_o
);
    logic refuse;

    assign refuse = (dlv_prio >= st_i.cur) ||
                    (st_i.src != '0 && st_i.pend <= dlv_prio);

    // Refuse, or take the offer and displace any owned pending entry.
    always_comb begin
        st_o   = st_i;
        rej_o  = 1'b0;
        disp_o = '0;
        if (dlv_valid) begin
            if (refuse) begin
                rej_o = 1'b1;
            end else begin
                if (st_i.src != '0 && st_i.own_v) disp_o = '{1'b1, st_i.src, st_i.own};
                st_o.src   = dlv_src;
                st_o.pend  = dlv_prio;
                st_o.own   = dlv_own;
                st_o.own_v = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_presenter.sv
// Per-processor interrupt presentation unit: single pending slot, priority
// gate, IPI arbitration. Command is applied before a same-cycle delivery;
// all pulses and read data are registered (one cycle latency).
module irq_presenter
    import irqp_pkg::*;
#(
    parameter logic [SRC_W-1:0] IPI_SRC = 24'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dlv_valid_i,
    input  logic [SRC_W-1:0]  dlv_src_i,
    input  logic [PRIO_W-1:0] dlv_prio_i,
    input  logic [OWN_W-1:0]  dlv_own_i,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [WORD_W-1:0] cmd_data_i,
    output logic              cpu_irq_o,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_word_o,
    output logic [PRIO_W-1:0] rd_ipi_o,
    output logic              dlv_rej_o,
    output logic              disp_o,
    output logic [SRC_W-1:0]  disp_src_o,
    output logic [OWN_W-1:0]  disp_own_o,
    output logic              eoi_o,
    output logic [SRC_W-1:0]  eoi_src_o,
    output logic              resend_o
);
    slot_t            state_q, st_cmd, st_dlv;
    disp_t            disp_cmd, disp_dlv, disp_any;
    logic             eoi_c, resend_c, rd_c, rej_c;
    logic [SRC_W-1:0] eoi_src_c;
    op_e              op;

    assign op = op_e'(cmd_op_i);

    irqp_cmd_stage #(.IPI_SRC(IPI_SRC)) u_cmd (
        .cmd_valid (cmd_valid_i),
        .cmd_op    (op),
        .cmd_data  (cmd_data_i),
        .st_i      (state_q),
        .st_o      (st_cmd),
        .disp_o    (disp_cmd),
        .eoi_o     (eoi_c),
        .eoi_src_o (eoi_src_c),
        .resend_o  (resend_c),
        .rd_o      (rd_c)
    );

    irqp_dlv_stage u_dlv (
        .dlv_valid (dlv_valid_i),
        .dlv_src   (dlv_src_i),
        .dlv_prio  (dlv_prio_i),
        .dlv_own   (dlv_own_i),
        .st_i      (st_cmd),
        .st_o      (st_dlv),
        .rej_o     (rej_c),
        .disp_o    (disp_dlv)
    );

    assign disp_any  = disp_cmd.v ? disp_cmd : disp_dlv;
    assign cpu_irq_o = (state_q.src != '0);

    // Slot state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '{cur: '0, src: '0, pend: PRIO_NONE, own: '0, own_v: 1'b0, ipi: PRIO_NONE};
        else        state_q <= st_dlv;
    end

    // Registered result pulses and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0; rd_word_o  <= '0; rd_ipi_o  <= '0;
            dlv_rej_o  <= 1'b0; disp_o     <= 1'b0; disp_src_o <= '0; disp_own_o <= '0;
            eoi_o      <= 1'b0; eoi_src_o  <= '0; resend_o  <= 1'b0;
        end else begin
            rd_valid_o <= rd_c;
            rd_word_o  <= rd_c ? {state_q.cur, state_q.src} : '0;
            rd_ipi_o   <= rd_c ? state_q.ipi : '0;
            dlv_rej_o  <= rej_c;
            disp_o     <= disp_any.v;
            disp_src_o <= disp_any.src;
            disp_own_o <= disp_any.own;
            eoi_o      <= eoi_c;
            eoi_src_o  <= eoi_src_c;
            resend_o   <= resend_c;
        end
    end

    // R2: an offer at or below the current priority is refused one cycle later.
    a_r2_low_offer_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid_i && !cmd_valid_i && dlv_prio_i >= state_q.cur) |=> dlv_rej_o);

    // R3: command and delivery never both displace in the same cycle.
    a_r3_single_displace: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_cmd.v && disp_dlv.v));

    // R4: an empty slot always carries the least favoured pending priority.
    a_r4_empty_slot_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.src == '0) |-> (state_q.pend == PRIO_NONE));

    // R4: accept with no delivery leaves the line low.
    a_r4_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_ACCEPT && !dlv_valid_i) |=> !cpu_irq_o);

    // R9: poll alone leaves the slot untouched.
    a_r9_poll_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op == OP_POLL && !dlv_valid_i) |=> $stable(state_q));

    // R11: read data only follows an accept or a poll.
    a_r11_read_source: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(cmd_valid_i && (op == OP_ACCEPT || op == OP_POLL)));
endmodule

// File: tb/irq_presenter_tb.sv
module irq_presenter_tb;
    typedef struct packed {
        logic [2:0]  op;  logic [31:0] cd;
        logic        dv;  logic [23:0] ds; logic [7:0] dp; logic [3:0] dow;
        logic        e_irq; logic e_rd; logic [31:0] e_word; logic [7:0] e_ipi;
        logic        e_rej; logic e_disp; logic [23:0] e_dsrc; logic [3:0] e_down;
        logic        e_eoi; logic [23:0] e_esrc; logic e_rs; logic [7:0] req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{0,0,1,'h10,5,1,             0,0,0,0,        1,0,0,0,      0,0,0, 2},  // R2 below cur 0
        '{1,'hFF,0,0,0,0,             0,0,0,0,        0,0,0,0,      0,0,1, 6},  // R6 resend
        '{0,0,1,'h10,5,1,             1,0,0,0,        0,0,0,0,      0,0,0, 11}, // R11 taken
        '{0,0,1,'h20,7,2,             1,0,0,0,        1,0,0,0,      0,0,0, 2},  // R2 weaker than pending
        '{0,0,1,'h30,3,3,             1,0,0,0,        0,1,'h10,1,   0,0,0, 3},  // R3 displace owned
        '{4,0,0,0,0,0,                1,1,'hFF000030,'hFF, 0,0,0,0, 0,0,0, 9},  // R9 poll
        '{0,0,1,'h40,3,2,             1,0,0,0,        1,0,0,0,      0,0,0, 2},  // R2 equal to pending
        '{1,'h03,0,0,0,0,             0,0,0,0,        0,1,'h30,3,   0,0,0, 5},  // R5 drop pending
        '{0,0,1,'h50,3,4,             0,0,0,0,        1,0,0,0,      0,0,0, 2},  // R2 equal to cur
        '{0,0,1,'h50,2,4,             1,0,0,0,        0,0,0,0,      0,0,0, 11}, // R11
        '{3,0,0,0,0,0,                0,1,'h03000050,'hFF, 0,0,0,0, 0,0,0, 4},  // R4 accept
        '{2,'h01,0,0,0,0,             1,0,0,0,        0,0,0,0,      0,0,0, 7},  // R7 IPI raised
        '{3,0,0,0,0,0,                0,1,'h02000002,'h01, 0,0,0,0, 0,0,0, 4},  // R4 accept IPI
        '{5,'hFF000002,0,0,0,0,       1,0,0,0,        0,0,0,0,      1,2,1, 8},  // R8 eoi + IPI again
        '{3,0,0,0,0,0,                0,1,'hFF000002,'h01, 0,0,0,0, 0,0,0, 4},  // R4
        '{2,'hFF,0,0,0,0,             0,0,0,0,        0,0,0,0,      0,0,0, 7},  // R7 not favoured
        '{5,'hFF000002,0,0,0,0,       0,0,0,0,        0,0,0,0,      1,2,1, 8},  // R8 resend no IPI
        '{0,0,1,'h60,4,5,             1,0,0,0,        0,0,0,0,      0,0,0, 11}, // R11
        '{2,'h04,0,0,0,0,             1,0,0,0,        0,0,0,0,      0,0,0, 7},  // R7 pending as good
        '{2,'h02,0,0,0,0,             1,0,0,0,        0,1,'h60,5,   0,0,0, 7},  // R7 IPI displaces
        '{0,0,1,'h70,1,6,             1,0,0,0,        0,0,0,0,      0,0,0, 3},  // R3 IPI silent
        '{3,0,1,'h80,0,7,             1,1,'hFF000070,'h02, 0,0,0,0, 0,0,0, 10}, // R10 accept then take
        '{4,0,0,0,0,0,                1,1,'h01000080,'h02, 0,0,0,0, 0,0,0, 9},  // R9
        '{1,'h00,1,'h90,0,1,          0,0,0,0,        1,1,'h80,7,   0,0,0, 10}, // R10 drop then refuse
        '{1,'h10,0,0,0,0,             1,0,0,0,        0,0,0,0,      0,0,1, 6},  // R6 resend + IPI
        '{5,'h20000033,0,0,0,0,       1,0,0,0,        0,0,0,0,      1,'h33,0, 8}, // R8 pending, no resend
        '{4,0,0,0,0,0,                1,1,'h20000002,'h02, 0,0,0,0, 0,0,0, 8}   // R8 cur loaded
    };

    logic        clk = 0, rst_n = 0;
    logic        dlv_valid = 0, cmd_valid = 0;
    logic [23:0] dlv_src = 0;  logic [7:0] dlv_prio = 0; logic [3:0] dlv_own = 0;
    logic [2:0]  cmd_op = 0;   logic [31:0] cmd_data = 0;
    logic        cpu_irq, rd_valid, dlv_rej, disp, eoi, resend;
    logic [31:0] rd_word; logic [7:0] rd_ipi;
    logic [23:0] disp_src, eoi_src; logic [3:0] disp_own;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    irq_presenter u_dut (
        .clk(clk), .rst_n(rst_n),
        .dlv_valid_i(dlv_valid), .dlv_src_i(dlv_src), .dlv_prio_i(dlv_prio), .dlv_own_i(dlv_own),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
        .cpu_irq_o(cpu_irq), .rd_valid_o(rd_valid), .rd_word_o(rd_word), .rd_ipi_o(rd_ipi),
        .dlv_rej_o(dlv_rej), .disp_o(disp), .disp_src_o(disp_src), .disp_own_o(disp_own),
        .eoi_o(eoi), .eoi_src_o(eoi_src), .resend_o(resend)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, sample results at the next falling edge.
    task automatic apply(input vec_t v);
        string r;
        cmd_valid = (v.op != 0); cmd_op = v.op; cmd_data = v.cd;
        dlv_valid = v.dv; dlv_src = v.ds; dlv_prio = v.dp; dlv_own = v.dow;
        @(negedge clk);
        cmd_valid = 0; dlv_valid = 0;
        r = $sformatf("R%0d", v.req);
        n_chk++;
        chk(r, "irq", cpu_irq, v.e_irq);
        chk(r, "rd_valid", rd_valid, v.e_rd);
        if (v.e_rd) begin chk(r, "word", rd_word, v.e_word); chk(r, "ipi", rd_ipi, v.e_ipi); end
        chk(r, "reject", dlv_rej, v.e_rej);
        chk(r, "disp", disp, v.e_disp);
        if (v.e_disp) begin chk(r, "disp_src", disp_src, v.e_dsrc); chk(r, "disp_own", disp_own, v.e_down); end
        chk(r, "eoi", eoi, v.e_eoi);
        if (v.e_eoi) chk(r, "eoi_src", eoi_src, v.e_esrc);
        chk(r, "resend", resend, v.e_rs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state on the ports
        n_chk++;
        chk("R1", "irq", cpu_irq, 0);
        chk("R1", "pulses", {rd_valid, dlv_rej, disp, eoi, resend}, 0);
        apply('{4,0,0,0,0,0, 0,1,0,'hFF, 0,0,0,0, 0,0,0, 1});  // R1 poll after reset
        for (int i = 0; i < NV; i++) apply(VEC[i]);
        // R1: reset in mid-operation restores the idle word
        rst_n = 0; @(negedge clk); rst_n = 1;
        apply('{4,0,0,0,0,0, 0,1,0,'hFF, 0,0,0,0, 0,0,0, 1});
        // R2: after reset current priority is 0, so even priority 0 is refused
        apply('{0,0,1,'h11,0,2, 0,0,0,0, 1,0,0,0, 0,0,0, 2});
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule